// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial stream on a single line. The host offers a character on a valid/ready input. An accepted character sits in a one-entry holding register. It moves into a frame shifter as soon as the shifter is free. The shifter then sends a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. Between frames the line rests high.

Bit timing comes from an external transmit clock. It arrives as a one-cycle enable pulse, `tick_in`, which is synchronous to `clk`. A bit lasts 1, 16 or 64 of these pulses. Frame format and divide ratio are captured when a character enters the shifter. Settings can therefore change at any time without damaging the frame on the line.

The input follows valid/ready rules. A character transfers on a `clk` rising edge where `in_valid` and `in_ready` are both high. `in_ready` is the holding-register-empty status. While it is low, the host keeps `in_valid` and `in_data` steady. Nothing the host presents in that time is taken in. Because the holding register refills while a frame is still being sent, back-to-back characters leave with no idle time between them.

Top module: `serial_tx_core`

## Requirements
- R1: After reset `txd` is high and `in_ready` is high, and `txd` stays high whenever no frame is being sent.
- R2: A frame starts with `txd` low in the cycle after the character enters the shifter. Each bit, the start bit included, holds `txd` steady for one full bit period.
- R3: `div_sel` 0 gives 1 `tick_in` pulse per bit, 1 gives 16 and 2 or 3 gives 64. A bit ends on the clock edge that counts its last pulse.
- R4: With `nine_bit` low, `in_data[7:0]` is sent as 8 data bits. With `nine_bit` high, `in_data[8:0]` is sent as 9 data bits. Either way the least significant bit goes first.
- R5: With `par_en` high, one parity bit follows the data. With `par_odd` low it makes the count of ones in data plus parity even. With `par_odd` high it makes that count odd.
- R6: With `par_en` low, the first stop bit comes straight after the last data bit.
- R7: `two_stop` low sends one high stop bit and `two_stop` high sends two.
- R8: A character is accepted only on an edge where `in_valid` and `in_ready` are both high. `in_ready` is low in the cycle after an acceptance. Data presented while `in_ready` is low does not change what is sent.
- R9: When a held character moves into the shifter, `in_ready` is high in the next cycle.
- R10: If a character is held when the last stop bit ends, its start bit begins in the very next cycle, with no idle bit period.
- R11: `nine_bit`, `par_en`, `par_odd`, `two_stop` and `div_sel` are captured when a character enters the shifter. Changing them mid-frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_in | input | 1 | Transmit clock enable, one pulse per transmit clock |
| div_sel | input | 2 | Ticks per bit: 0 gives 1, 1 gives 16, 2 or 3 gives 64 |
| nine_bit | input | 1 | High for 9 data bits, low for 8 |
| par_en | input | 1 | High to append a parity bit |
| par_odd | input | 1 | High for odd parity, low for even |
| two_stop | input | 1 | High for two stop bits |
| in_valid | input | 1 | Host offers a character |
| in_data | input | 9 | Character; bit 8 is used only in 9-bit mode |
| in_ready | output | 1 | Holding register empty; a character may be accepted |
| txd | output | 1 | Serial data output, idle high |

## Verification
If the bit counter or the shifter position holds a wrong value, `txd` goes wrong within one bit period. The error shows up as a bit edge at the wrong tick or as a wrong level. If the holding register's full state is wrong, `in_ready` differs at once, or a frame starts late or is repeated. A reference model that follows the line every clock catches these in the cycle they first appear. A format captured at the wrong moment only shows at the parity or stop-bit position, so the mid-frame format changes are timed to land before those bits.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
  typedef struct packed {
    logic nine;
    logic par_en;
    logic par_odd;
    logic two_stop;
  } tx_fmt_t;

  typedef enum logic [1:0] {
    DIV_ONE  = 2'd0,
    DIV_MID  = 2'd1,
    DIV_HI   = 2'd2,
    DIV_HI_B = 2'd3
  } div_sel_e;
endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             tick,
  input  logic [DIV_W-1:0] last,
  output logic             bit_end
);
  logic [DIV_W-1:0] cnt;

  assign bit_end = run && tick && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (restart)
      cnt <= '0;
    else if (run && tick)
      cnt <= bit_end ? '0 : cnt + 1'b1;
  end

  // R3: while a frame runs, the tick count never passes the bit length
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt <= last);
endmodule

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              pull,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  assign in_ready = !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (in_valid && !full) begin
      full <= 1'b1;
      data <= in_data;
    end else if (pull) begin
      full <= 1'b0;
    end
  end

  p_ready_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  p_ready_returns_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pull |=> in_ready);
endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter
  import serial_tx_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int DIV_MID_N = 16,
  parameter int DIV_HI_N  = 64,
  parameter int DIV_W   = $clog2(DIV_HI_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  tx_fmt_t           fmt,
  input  logic [1:0]        div_sel,
  input  logic              bit_end,
  output logic              pull,
  output logic              busy,
  output logic [DIV_W-1:0]  last_tick,
  output logic              txd
);
  localparam int FR_W  = DATA_W + 4;
  localparam int CNT_W = $clog2(FR_W + 1);

  logic [FR_W-1:0]  sh;
  logic [CNT_W-1:0] left;
  logic [FR_W-1:0]  frame;
  logic [CNT_W-1:0] total;
  logic [DIV_W-1:0] last_new;
  logic             final_end;

  always_comb begin
    logic [DATA_W:0] dx;
    int              nb;
    logic            par;
    dx = {1'b0, hold_data};
    nb = fmt.nine ? DATA_W : DATA_W - 1;
    par = fmt.par_odd;
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i <= DATA_W; i++) begin
      if (i < nb) begin
        frame[i+1] = dx[i];
        par = par ^ dx[i];
      end
    end
    for (int i = 0; i <= DATA_W; i++)
      if (i == nb && fmt.par_en) frame[i+1] = par;
    total = CNT_W'(1 + nb + (fmt.par_en ? 1 : 0) + (fmt.two_stop ? 2 : 1));
    case (div_sel_e'(div_sel))
      DIV_ONE: last_new = '0;
      DIV_MID: last_new = DIV_W'(DIV_MID_N - 1);
      default: last_new = DIV_W'(DIV_HI_N - 1);
    endcase
  end

  assign final_end = bit_end && (left == CNT_W'(1));
  assign pull      = hold_full && (!busy || final_end);
  assign txd       = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '1;
      left      <= '0;
      busy      <= 1'b0;
      last_tick <= '0;
    end else if (pull) begin
      sh        <= frame;
      left      <= total;
      busy      <= 1'b1;
      last_tick <= last_new;
    end else if (bit_end) begin
      sh   <= {1'b1, sh[FR_W-1:1]};
      left <= left - 1'b1;
      if (final_end) busy <= 1'b0;
    end
  end

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pull |=> !txd);
endmodule

// File: rtl/serial_tx_core.sv
module serial_tx_core
  import serial_tx_pkg::*;
#(
  parameter int DATA_W    = 9,
  parameter int DIV_MID_N = 16,
  parameter int DIV_HI_N  = 64,
  localparam int DIV_W    = $clog2(DIV_HI_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic [1:0]        div_sel,
  input  logic              nine_bit,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              txd
);
  tx_fmt_t          fmt;
  logic             pull, hold_full, busy, bit_end;
  logic [DATA_W-1:0] hold_data;
  logic [DIV_W-1:0] last_tick;

  assign fmt = '{nine: nine_bit, par_en: par_en, par_odd: par_odd, two_stop: two_stop};

  tx_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .pull(pull), .full(hold_full), .data(hold_data));

  tx_frame_shifter #(.DATA_W(DATA_W), .DIV_MID_N(DIV_MID_N), .DIV_HI_N(DIV_HI_N),
                     .DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .hold_full(hold_full), .hold_data(hold_data),
    .fmt(fmt), .div_sel(div_sel), .bit_end(bit_end), .pull(pull),
    .busy(busy), .last_tick(last_tick), .txd(txd));

  tx_bit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .restart(pull), .tick(tick_in),
    .last(last_tick), .bit_end(bit_end));

  // R2: the line holds its level until the timer closes the bit
  p_bit_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !bit_end |=> $stable(txd));
endmodule

// File: tb/serial_tx_core_tb.sv
module serial_tx_core_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_in = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic nine_bit = 1'b0, par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
  logic in_valid = 1'b0;
  logic [8:0] in_data = '0;
  logic in_ready, txd;

  always #2.5 clk = ~clk;

  serial_tx_core u_dut (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .div_sel(div_sel),
    .nine_bit(nine_bit), .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .txd(txd));

  int n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  int tick_period = 1;
  int tick_ph = 0;
  bit done = 0;

  // behavioural reference model
  bit m_busy, m_full, m_take, m_bend, m_lastend, m_ld, m_par;
  bit [8:0] m_hold;
  int m_cnt, m_lim, m_nb;
  bit m_bits[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_full = 0; m_hold = '0; m_cnt = 0; m_lim = 1;
      m_bits.delete();
    end else begin
      m_take    = in_valid && !m_full;
      m_bend    = m_busy && tick_in && (m_cnt == m_lim - 1);
      m_lastend = m_bend && (m_bits.size() == 1);
      m_ld      = m_full && (!m_busy || m_lastend);
      if (m_busy && tick_in) m_cnt = m_bend ? 0 : m_cnt + 1;
      if (m_bend) void'(m_bits.pop_front());
      if (m_ld) begin
        m_bits.delete();
        m_nb = nine_bit ? 9 : 8;
        m_par = par_odd;
        m_bits.push_back(1'b0);
        for (int i = 0; i < m_nb; i++) begin
          m_bits.push_back(m_hold[i]);
          m_par = m_par ^ m_hold[i];
        end
        if (par_en) m_bits.push_back(m_par);
        m_bits.push_back(1'b1);
        if (two_stop) m_bits.push_back(1'b1);
        m_cnt = 0; m_busy = 1; m_full = 0;
        m_lim = (div_sel == 2'd0) ? 1 : (div_sel == 2'd1) ? 16 : 64;
      end else if (m_lastend) m_busy = 0;
      if (m_take) begin m_full = 1; m_hold = in_data; end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_req, txd, m_busy ? m_bits[0] : 1'b1);
      check("R8 R9", in_ready, !m_full);
    end
    tick_ph = (tick_ph + 1) % tick_period;
    tick_in <= (tick_ph == 0);
  end

  task automatic send(input logic [8:0] d);
    in_valid = 1'b1; in_data = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_data = 9'h1FF;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy || m_full) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", txd, 1'b1);
    check("R1", in_ready, 1'b1);

    cur_req = "R2 R6 R7";
    send(9'h0A5); wait_idle();

    cur_req = "R3 R5 R7";
    div_sel = 2'd1; par_en = 1; par_odd = 0; two_stop = 1; tick_period = 3;
    send(9'h03C); wait_idle();

    cur_req = "R3";
    div_sel = 2'd3; par_en = 0; two_stop = 0; tick_period = 1;
    send(9'h081); wait_idle();

    cur_req = "R4 R5";
    div_sel = 2'd0; nine_bit = 1; par_en = 1; par_odd = 1; tick_period = 2;
    send(9'h1A5); send(9'h0FF); wait_idle();

    cur_req = "R10 R8";
    nine_bit = 0; par_en = 0; two_stop = 0; tick_period = 1;
    send(9'h055); send(9'h0F0); send(9'h00F);
    in_valid = 1'b1; in_data = 9'h133;
    @(negedge clk); in_data = 9'h0CC;
    while (!in_ready) begin @(negedge clk); in_data = in_data ^ 9'h011; end
    @(negedge clk); in_valid = 1'b0;
    wait_idle();

    cur_req = "R11";
    div_sel = 2'd1; tick_period = 1;
    send(9'h0C3);
    repeat (20) @(negedge clk);
    div_sel = 2'd0; nine_bit = 1; par_en = 1; two_stop = 1;
    wait_idle();
    send(9'h16A); wait_idle();

    done = 1;
    finish_run();
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end
endmodule